// File: doc/BRIEF.md
# Sequentially Loaded Routing Configuration Bank

This block holds the configuration words for a set of signal-routing multiplexers. Software cannot address these words one at a time. It reaches them through three bus registers: a control register, a data-in port and a data-out port. Each write to the data-in port places the word in the next slot, and a write counter tracks which slot that is. Each read of the data-out port returns the next slot in the same order, and a separate read counter tracks that position. A strobe bit in the control register sends both counters back to slot 0.

An enable bit in the control register gates the routing. While the bit is 0, every cell-facing line leaving the block is held at 0. Every pin-facing data line is also held at 0 and its output enable is deasserted, so no half-loaded configuration reaches the pins. Downstream multiplexers read the stored words directly from a flat bus. Slots 16 to 23 are the input-selector words, two for each group of eight cells. The even slot of each pair serves selector lines 0 to 3, and the odd slot serves lines 4 to 7.

To program the bank, software clears the enable bit, pulses the counter reset, writes the words in order, checks the reported write count, and then sets the enable bit. The register bus has no back-pressure. Every strobe is accepted in the cycle it is raised, with no ready signal. Read data is combinational from the address, and a data-out read advances the read counter at the edge that ends the strobe cycle.

Top module: `cfg_seq_array`

## Requirements
- R1: After reset, the enable bit is 0, the write count is 0, the overflow flag is 0 and every stored word is 0.
- R2: Reading the control register (address 0) returns the enable bit in bit 0, 0 in bit 1, the overflow flag in bit 2 and the write count in bits 12:8. All other bits read 0.
- R3: While the enable bit is 0 and fewer than NUM_REGS words are loaded, a write to data-in (address 2) stores the word in the slot named by the write count, and the count then rises by one.
- R4: A data-in write made when all NUM_REGS slots are full changes no slot and no count, and sets the overflow flag. The flag stays set until the next counter reset.
- R5: Reading data-out (address 1) returns the slot named by the read counter, and the counter then advances. After the last slot it wraps to slot 0.
- R6: Writing the control register with bit 1 set clears the write count, the read counter and the overflow flag. Bit 1 itself is never stored.
- R7: A data-in write made while the enable bit is 1 changes no slot, no count and no flag.
- R8: While the enable bit is 0, cell_o and pin_o are all 0 and pin_oe_o is all 0. While it is 1, these outputs equal the matching route inputs.
- R9: cfg_o always carries slot k in bits [k*DATA_W +: DATA_W], whatever the state of the enable bit.
- R10: Reads of address 3 return 0, and writes to address 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 control, 1 data-out, 2 data-in |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe; it has a side effect only at address 1 |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the addressed register |
| route_cell_i | input | CELL_N | Cell-facing lines from the crossbar |
| route_pin_i | input | PIN_N | Pin-facing data from the crossbar |
| route_pin_oe_i | input | PIN_N | Pin output enables from the crossbar |
| cell_o | output | CELL_N | Gated cell lines |
| pin_o | output | PIN_N | Gated pin data |
| pin_oe_o | output | PIN_N | Gated pin output enables |
| cfg_o | output | NUM_REGS*DATA_W | Stored configuration words, flattened |

## Verification
The bench loads all 24 slots with words computed by a formula. It checks each slot on cfg_o and reads the whole bank back twice through data-out. A pointer that failed to wrap, or started from the wrong slot, would return shifted words on the second pass. It then writes past the last slot. A counter that wrapped instead of saturating would overwrite slot 0, and a flag that was not sticky would clear on the next access. The bench also writes while the bank is enabled, which a missing gate would let through to the words. It drives several route patterns with the enable bit in each state, and a leaky gate would show nonzero cell or pin outputs or an asserted output enable.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_DOUT = 2'd1;
  localparam logic [1:0] ADDR_DIN  = 2'd2;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_CLR_BIT = 1;
  localparam int CTRL_OVF_BIT = 2;
  localparam int CTRL_CNT_LSB = 8;
endpackage

// File: rtl/cfg_seq_store.sv
module cfg_seq_store #(
  parameter int NUM_REGS = 24,
  parameter int DATA_W   = 16,
  localparam int CNT_W   = $clog2(NUM_REGS + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       we,
  input  logic [DATA_W-1:0]          wdata,
  output logic [CNT_W-1:0]           wcnt,
  output logic                       ovf,
  output logic [NUM_REGS*DATA_W-1:0] words
);
  logic full;
  assign full = (wcnt == CNT_W'(NUM_REGS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt <= '0;
      ovf  <= 1'b0;
    end else if (clr) begin
      wcnt <= '0;
      ovf  <= 1'b0;
    end else if (we) begin
      if (full) ovf  <= 1'b1;
      else      wcnt <= wcnt + 1'b1;
    end
  end

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        words[k*DATA_W +: DATA_W] <= '0;
      else if (we && !clr && wcnt == CNT_W'(k))
        words[k*DATA_W +: DATA_W] <= wdata;
    end
  end
endmodule

// File: rtl/cfg_seq_rdptr.sv
module cfg_seq_rdptr #(
  parameter int NUM_REGS = 24,
  localparam int PTR_W   = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  output logic [PTR_W-1:0] rcnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               rcnt <= '0;
    else if (clr)                             rcnt <= '0;
    else if (adv) begin
      if (rcnt == PTR_W'(NUM_REGS - 1))       rcnt <= '0;
      else                                    rcnt <= rcnt + 1'b1;
    end
  end
endmodule

// File: rtl/cfg_seq_gate.sv
module cfg_seq_gate #(
  parameter int CELL_N = 8,
  parameter int PIN_N  = 8
) (
  input  logic              en,
  input  logic [CELL_N-1:0] cell_i,
  input  logic [PIN_N-1:0]  pin_i,
  input  logic [PIN_N-1:0]  pin_oe_i,
  output logic [CELL_N-1:0] cell_o,
  output logic [PIN_N-1:0]  pin_o,
  output logic [PIN_N-1:0]  pin_oe_o
);
  for (genvar c = 0; c < CELL_N; c++) begin : g_cell
    assign cell_o[c] = en & cell_i[c];
  end
  for (genvar p = 0; p < PIN_N; p++) begin : g_pin
    assign pin_o[p]    = en & pin_i[p];
    assign pin_oe_o[p] = en & pin_oe_i[p];
  end
endmodule

// File: rtl/cfg_seq_array.sv
module cfg_seq_array
  import cfg_seq_pkg::*;
#(
  parameter int NUM_REGS = 24,
  parameter int DATA_W   = 16,
  parameter int CELL_N   = 8,
  parameter int PIN_N    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 bus_addr,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  input  logic [CELL_N-1:0]          route_cell_i,
  input  logic [PIN_N-1:0]           route_pin_i,
  input  logic [PIN_N-1:0]           route_pin_oe_i,
  output logic [CELL_N-1:0]          cell_o,
  output logic [PIN_N-1:0]           pin_o,
  output logic [PIN_N-1:0]           pin_oe_o,
  output logic [NUM_REGS*DATA_W-1:0] cfg_o
);
  localparam int CNT_W = $clog2(NUM_REGS + 1);
  localparam int PTR_W = $clog2(NUM_REGS);

  logic             en_q;
  logic             ctrl_we, din_we, dout_re, cnt_clr;
  logic [CNT_W-1:0] wcnt;
  logic [PTR_W-1:0] rcnt;
  logic             ovf;
  logic [DATA_W-1:0] ctrl_view, dout_view;

  assign ctrl_we = bus_wr && bus_addr == ADDR_CTRL;
  assign din_we  = bus_wr && bus_addr == ADDR_DIN;
  assign dout_re = bus_rd && bus_addr == ADDR_DOUT;
  assign cnt_clr = ctrl_we && bus_wdata[CTRL_CLR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= 1'b0;
    else if (ctrl_we) en_q <= bus_wdata[CTRL_EN_BIT];
  end

  cfg_seq_store #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .we    (din_we && !en_q),
    .wdata (bus_wdata),
    .wcnt  (wcnt),
    .ovf   (ovf),
    .words (cfg_o)
  );

  cfg_seq_rdptr #(.NUM_REGS(NUM_REGS)) u_rdptr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .adv   (dout_re),
    .rcnt  (rcnt)
  );

  cfg_seq_gate #(.CELL_N(CELL_N), .PIN_N(PIN_N)) u_gate (
    .en       (en_q),
    .cell_i   (route_cell_i),
    .pin_i    (route_pin_i),
    .pin_oe_i (route_pin_oe_i),
    .cell_o   (cell_o),
    .pin_o    (pin_o),
    .pin_oe_o (pin_oe_o)
  );

  always_comb begin
    ctrl_view = '0;
    ctrl_view[CTRL_EN_BIT]  = en_q;
    ctrl_view[CTRL_OVF_BIT] = ovf;
    ctrl_view[CTRL_CNT_LSB +: CNT_W] = wcnt;
  end

  assign dout_view = cfg_o[int'(rcnt)*DATA_W +: DATA_W];

  always_comb begin
    unique case (bus_addr)
      ADDR_CTRL: bus_rdata = ctrl_view;
      ADDR_DOUT: bus_rdata = dout_view;
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cfg_seq_array_chk.sv
module cfg_seq_array_chk #(
  parameter int NUM_REGS = 24,
  parameter int DATA_W   = 16,
  parameter int CELL_N   = 8,
  parameter int PIN_N    = 8,
  localparam int CNT_W   = $clog2(NUM_REGS + 1)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       en_q,
  input logic                       din_we,
  input logic                       cnt_clr,
  input logic [CNT_W-1:0]           wcnt,
  input logic                       ovf,
  input logic [NUM_REGS*DATA_W-1:0] cfg_o,
  input logic [CELL_N-1:0]          cell_o,
  input logic [PIN_N-1:0]           pin_o,
  input logic [PIN_N-1:0]           pin_oe_o
);
  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt <= CNT_W'(NUM_REGS));

  assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !cnt_clr) |=> ovf);

  assert_count_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (din_we && !en_q && !cnt_clr && wcnt < CNT_W'(NUM_REGS)) |=> wcnt == $past(wcnt) + 1'b1);

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (wcnt == '0 && !ovf));

  assert_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (din_we && en_q) |=> $stable(cfg_o));

  assert_safe_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (cell_o == '0 && pin_o == '0 && pin_oe_o == '0));
endmodule

bind cfg_seq_array cfg_seq_array_chk #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .CELL_N(CELL_N), .PIN_N(PIN_N)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en_q     (en_q),
  .din_we   (din_we),
  .cnt_clr  (cnt_clr),
  .wcnt     (wcnt),
  .ovf      (ovf),
  .cfg_o    (cfg_o),
  .cell_o   (cell_o),
  .pin_o    (pin_o),
  .pin_oe_o (pin_oe_o)
);

// File: tb/cfg_seq_array_bench.sv
module cfg_seq_array_bench;
  localparam int NR = 24;
  localparam int DW = 16;
  localparam int CN = 8;
  localparam int PN = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [CN-1:0] route_cell_i = '0;
  logic [PN-1:0] route_pin_i = '0, route_pin_oe_i = '0;
  logic [CN-1:0] cell_o;
  logic [PN-1:0] pin_o, pin_oe_o;
  logic [NR*DW-1:0] cfg_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cfg_seq_array #(.NUM_REGS(NR), .DATA_W(DW), .CELL_N(CN), .PIN_N(PN)) u_cfg_seq_array (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .route_cell_i(route_cell_i),
    .route_pin_i(route_pin_i), .route_pin_oe_i(route_pin_oe_i), .cell_o(cell_o),
    .pin_o(pin_o), .pin_oe_o(pin_oe_o), .cfg_o(cfg_o)
  );

  function automatic logic [DW-1:0] word_of(int k);
    return DW'(k * 16'h0111) ^ 16'hA5C3;
  endfunction

  function automatic logic [DW-1:0] ctrl_of(bit en, bit ovf, int cnt);
    return DW'({cnt[4:0], 5'b0, ovf, 1'b0, en});
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic gate_sweep(bit en);
    for (int p = 0; p < 4; p++) begin
      @(negedge clk);
      route_cell_i   = CN'(8'h5A << p) | CN'(p);
      route_pin_i    = ~PN'(p * 37);
      route_pin_oe_i = PN'(8'hC3 >> p);
      #1;
      check("R8 cell", DW'(cell_o), en ? DW'(route_cell_i) : '0);
      check("R8 pin",  DW'(pin_o),  en ? DW'(route_pin_i) : '0);
      check("R8 oe",   DW'(pin_oe_o), en ? DW'(route_pin_oe_i) : '0);
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [DW-1:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R2 reset state
    bus_read(2'd0, r);
    check("R1 R2 ctrl after reset", r, ctrl_of(0, 0, 0));
    check("R1 cfg zero", DW'(|cfg_o), '0);
    gate_sweep(0);

    // R6 counter reset, R3 load all slots
    bus_write(2'd0, DW'(2));
    for (int k = 0; k < NR; k++) begin
      bus_write(2'd2, word_of(k));
      bus_read(2'd0, r);
      check("R3 count", r, ctrl_of(0, 0, k + 1));
    end
    for (int k = 0; k < NR; k++)
      check("R9 slot", cfg_o[k*DW +: DW], word_of(k));

    // R4 overflow
    bus_write(2'd2, 16'hDEAD);
    bus_write(2'd2, 16'hBEEF);
    bus_read(2'd0, r);
    check("R4 ovf flag", r, ctrl_of(0, 1, NR));
    check("R4 slot0 kept", cfg_o[0 +: DW], word_of(0));
    check("R4 last kept", cfg_o[(NR-1)*DW +: DW], word_of(NR-1));
    bus_read(2'd3, r);
    check("R4 sticky/R10 read", r, '0);
    bus_read(2'd0, r);
    check("R4 sticky", r, ctrl_of(0, 1, NR));

    // R5 read twice around with wrap
    for (int k = 0; k < 2 * NR; k++) begin
      bus_read(2'd1, r);
      check("R5 dout", r, word_of(k % NR));
    end

    // R10 write to unused address
    bus_write(2'd3, 16'hFFFF);
    bus_read(2'd0, r);
    check("R10 ctrl unchanged", r, ctrl_of(0, 1, NR));

    // R5 partial read, then R6 clears both counters and overflow
    bus_read(2'd1, r);
    bus_read(2'd1, r);
    check("R5 second", r, word_of(1));
    bus_write(2'd0, DW'(2));
    bus_read(2'd0, r);
    check("R6 clear", r, ctrl_of(0, 0, 0));
    bus_read(2'd1, r);
    check("R6 rptr clear", r, word_of(0));

    // enable and R7 locked writes
    bus_write(2'd2, 16'h1234);
    check("R3 slot0 rewrite", cfg_o[0 +: DW], 16'h1234);
    bus_write(2'd0, DW'(1));
    bus_read(2'd0, r);
    check("R2 enabled", r, ctrl_of(1, 0, 1));
    bus_write(2'd2, 16'h7777);
    bus_read(2'd0, r);
    check("R7 count held", r, ctrl_of(1, 0, 1));
    check("R7 slot1 kept", cfg_o[DW +: DW], word_of(1));
    check("R9 visible while enabled", cfg_o[2*DW +: DW], word_of(2));
    gate_sweep(1);

    // R6 bit 1 with enable in same write
    bus_write(2'd0, DW'(3));
    bus_read(2'd0, r);
    check("R6 R2 clear bit reads 0", r, ctrl_of(1, 0, 0));
    bus_write(2'd0, DW'(0));
    gate_sweep(0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule